// File: doc/BRIEF.md
# Partitioned SIMD Comparator

This is a purely combinational compare unit for packed 16-bit data. A run-time partition vector splits the two operands into lanes at nibble boundaries. Each lane is compared unsigned against the matching lane of the other operand. The whole word can be one 16-bit lane, two 8-bit lanes or four 4-bit lanes. Mixed splits, such as 12+4, follow from the same rule.

All six relations are produced together for every lane: equal, not equal, less, less-or-equal, greater and greater-or-equal. Each result is a per-nibble flag vector with one bit per nibble. A lane's answer appears on the bit of its least significant nibble, and all other bits read zero. Downstream logic can therefore read a result at a fixed position, whatever split is chosen.

A single set of per-nibble comparators and carry-like chains serves every split. A set partition bit cuts the chain at that boundary.

Top module: `part_cmp`

## Requirements
- R1: All six result vectors are valid at the same time from the same inputs. Each vector has one bit per nibble (4 bits at the default width), and there is no clock or register on the path.
- R2: Bit k of `part_i` splits the operands between bit 4k+3 and bit 4k+4. The value 3'b000 gives one 16-bit lane, 3'b010 gives two 8-bit lanes and 3'b111 gives four 4-bit lanes.
- R3: `eq_o` bit i is 1 exactly when nibble i is the lowest nibble of a lane and that lane of `a_i` equals that lane of `b_i`.
- R4: `gt_o` and `lt_o` use an unsigned comparison of the lane's bits only. For example, a 4-bit lane holding 0xF against 0x1 reads as greater.
- R5: A lane's result does not depend on any operand bit outside that lane.
- R6: Within each lane, `ne_o` is the inverse of `eq_o`, `le_o` is lt OR eq, and `ge_o` is gt OR eq.
- R7: Result bits at nibble positions that are not the lowest nibble of a lane read 0 in all six vectors.
- R8: Partition values other than the three regular modes (such as 3'b001 or 3'b100) produce lanes of unequal width. These lanes follow the same rules as R3 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Operand A, packed lanes |
| b_i | input | 16 | Operand B, packed lanes |
| part_i | input | 3 | Partition bits; bit k cuts between nibble k and k+1 |
| eq_o | output | 4 | Per-lane equal flags at lane-low nibble |
| ne_o | output | 4 | Per-lane not-equal flags |
| lt_o | output | 4 | Per-lane unsigned less-than flags |
| le_o | output | 4 | Per-lane unsigned less-or-equal flags |
| gt_o | output | 4 | Per-lane unsigned greater-than flags |
| ge_o | output | 4 | Per-lane unsigned greater-or-equal flags |

## Verification
Operand pairs are applied in each of the three regular modes and in the irregular splits.

- Identical words, all-ones against all-zeros and MSB-only differences separate the eq path from the gt/lt paths.
- Pairs whose lanes differ only in a low nibble (0x1234 against 0x1235) show whether the chain carries equality down through a lane, and whether it stops at a cut.
- Opposite-order nibbles (0x00F1 against 0x001F) give different answers at different widths. This exposes a comparison that is signed or not masked to its lane.
- Pairs that change only one lane confirm that neighbouring lanes keep their flags.

// File: rtl/part_cmp_pkg.sv
package part_cmp_pkg;
  typedef struct packed {
    logic eq;
    logic gt;
  } nib_rel_t;
endpackage

// File: rtl/nib_cmp.sv
module nib_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0]           a_i,
  input  logic [W-1:0]           b_i,
  output part_cmp_pkg::nib_rel_t rel_o
);
  assign rel_o.eq = (a_i == b_i);
  assign rel_o.gt = (a_i > b_i);
endmodule

// File: rtl/lane_chain.sv
// Resolves lane results from MSB nibble downward; a set cut bit restarts the chain.
module lane_chain #(
  parameter int N = 4
) (
  input  part_cmp_pkg::nib_rel_t [N-1:0] rel_i,
  input  logic [N-2:0]                   cut_i,
  output logic [N-1:0]                   eq_o,
  output logic [N-1:0]                   gt_o,
  output logic [N-1:0]                   low_o
);
  for (genvar i = 0; i < N; i++) begin : g_nib
    if (i == N-1) begin : g_top
      assign eq_o[i] = rel_i[i].eq;
      assign gt_o[i] = rel_i[i].gt;
    end else begin : g_mid
      assign eq_o[i] = rel_i[i].eq & (cut_i[i] | eq_o[i+1]);
      assign gt_o[i] = cut_i[i] ? rel_i[i].gt
                                : (gt_o[i+1] | (eq_o[i+1] & rel_i[i].gt));
    end
    if (i == 0) begin : g_low0
      assign low_o[i] = 1'b1;
    end else begin : g_lown
      assign low_o[i] = cut_i[i-1];
    end
  end
endmodule

// File: rtl/rel_pack.sv
module rel_pack #(
  parameter int N = 4
) (
  input  logic [N-1:0] eq_i,
  input  logic [N-1:0] gt_i,
  input  logic [N-1:0] low_i,
  output logic [N-1:0] eq_o,
  output logic [N-1:0] ne_o,
  output logic [N-1:0] lt_o,
  output logic [N-1:0] le_o,
  output logic [N-1:0] gt_o,
  output logic [N-1:0] ge_o
);
  assign eq_o = low_i &  eq_i;
  assign ne_o = low_i & ~eq_i;
  assign gt_o = low_i &  gt_i;
  assign le_o = low_i & ~gt_i;
  assign lt_o = low_i & ~gt_i & ~eq_i;
  assign ge_o = low_i & (gt_i | eq_i);
endmodule

// File: rtl/part_cmp.sv
module part_cmp #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4,
  localparam int N     = DATA_W / NIB_W,
  localparam int PP    = N - 1
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [PP-1:0]     part_i,
  output logic [N-1:0]      eq_o,
  output logic [N-1:0]      ne_o,
  output logic [N-1:0]      lt_o,
  output logic [N-1:0]      le_o,
  output logic [N-1:0]      gt_o,
  output logic [N-1:0]      ge_o
);
  part_cmp_pkg::nib_rel_t [N-1:0] nib_rel;
  logic [N-1:0] eq_acc, gt_acc, low;

  for (genvar i = 0; i < N; i++) begin : g_nib
    nib_cmp #(.W(NIB_W)) u_nib (
      .a_i   (a_i[i*NIB_W +: NIB_W]),
      .b_i   (b_i[i*NIB_W +: NIB_W]),
      .rel_o (nib_rel[i])
    );
  end

  lane_chain #(.N(N)) u_chain (
    .rel_i (nib_rel),
    .cut_i (part_i),
    .eq_o  (eq_acc),
    .gt_o  (gt_acc),
    .low_o (low)
  );

  rel_pack #(.N(N)) u_pack (
    .eq_i  (eq_acc),
    .gt_i  (gt_acc),
    .low_i (low),
    .eq_o  (eq_o),
    .ne_o  (ne_o),
    .lt_o  (lt_o),
    .le_o  (le_o),
    .gt_o  (gt_o),
    .ge_o  (ge_o)
  );
endmodule

// File: rtl/part_cmp_chk.sv
module part_cmp_chk #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4,
  localparam int N     = DATA_W / NIB_W,
  localparam int PP    = N - 1
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [PP-1:0]     part_i,
  input logic [N-1:0]      eq_o,
  input logic [N-1:0]      ne_o,
  input logic [N-1:0]      lt_o,
  input logic [N-1:0]      le_o,
  input logic [N-1:0]      gt_o,
  input logic [N-1:0]      ge_o
);
  logic [N-1:0] low_c;
  assign low_c = {part_i, 1'b1};

  always_comb begin
    a_r7_nonlow_zero: assert (((eq_o | ne_o | lt_o | le_o | gt_o | ge_o) & ~low_c) == '0)
      else $error("R7 result bit set off lane-low position");
    a_r6_eq_ne_split: assert ((eq_o ^ ne_o) == low_c)
      else $error("R6 eq/ne not complementary");
    a_r6_le_ge_meet: assert ((le_o & ge_o) == eq_o)
      else $error("R6 le&ge differs from eq");
    a_r3_self_equal: assert (a_i != b_i || eq_o == low_c)
      else $error("R3 identical operands not all equal");
    for (int i = 0; i < N; i++) begin
      a_r4_trichotomy: assert (!low_c[i] || $countones({lt_o[i], eq_o[i], gt_o[i]}) == 1)
        else $error("R4 lane %0d not exactly one of lt/eq/gt", i);
    end
  end
endmodule

bind part_cmp part_cmp_chk #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_chk (.*);

// File: tb/part_cmp_tb.sv
module part_cmp_tb;
  localparam int DATA_W = 16;
  localparam int NIB_W  = 4;
  localparam int N      = DATA_W / NIB_W;
  localparam int PP     = N - 1;

  typedef struct {
    logic [N-1:0] eq, ne, lt, le, gt, ge, low;
    string        req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DATA_W-1:0] a, b;
  logic [PP-1:0] part;
  logic [N-1:0] eq, ne, lt, le, gt, ge;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  part_cmp #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_dut (
    .a_i(a), .b_i(b), .part_i(part),
    .eq_o(eq), .ne_o(ne), .lt_o(lt), .le_o(le), .gt_o(gt), .ge_o(ge)
  );

  function automatic exp_t model(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y,
                                 logic [PP-1:0] m, string req);
    exp_t e;
    int lo, hi;
    longint unsigned xv, yv, msk;
    e.eq = '0; e.ne = '0; e.lt = '0; e.le = '0; e.gt = '0; e.ge = '0; e.low = '0;
    e.req = req;
    lo = 0;
    while (lo < N) begin
      hi = lo;
      while (hi < N-1 && !m[hi]) hi++;
      msk = (64'd1 << ((hi - lo + 1) * NIB_W)) - 1;
      xv = (longint'(x) >> (lo * NIB_W)) & msk;
      yv = (longint'(y) >> (lo * NIB_W)) & msk;
      e.low[lo] = 1'b1;
      e.eq[lo] = (xv == yv);
      e.ne[lo] = (xv != yv);
      e.lt[lo] = (xv <  yv);
      e.le[lo] = (xv <= yv);
      e.gt[lo] = (xv >  yv);
      e.ge[lo] = (xv >= yv);
      lo = hi + 1;
    end
    return e;
  endfunction

  task automatic cmp(string tag, string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: a=%h b=%h part=%b act=%b exp=%b", req, tag, a, b, part, act, exp);
    end
  endtask

  task automatic drive(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y,
                       logic [PP-1:0] m, string req);
    @(posedge clk);
    #1;
    a = x; b = y; part = m;
    q.push_back(model(x, y, m, req));
  endtask

  // monitor: pops expectations and compares mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp("eq", {e.req, "/R3"}, eq, e.eq);
        cmp("ne", {e.req, "/R6"}, ne, e.ne);
        cmp("lt", {e.req, "/R4"}, lt, e.lt);
        cmp("le", {e.req, "/R6"}, le, e.le);
        cmp("gt", {e.req, "/R4"}, gt, e.gt);
        cmp("ge", {e.req, "/R6"}, ge, e.ge);
        cmp("offlane", {e.req, "/R7"}, (eq | ne | lt | le | gt | ge) & ~e.low, '0);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [DATA_W-1:0] pa [12] = '{16'h0000, 16'hFFFF, 16'h1234, 16'h1234, 16'h8000, 16'h00F1,
                                 16'hF0F0, 16'hA5A5, 16'hFFFF, 16'h0001, 16'h7FFF, 16'h0F00};
  logic [DATA_W-1:0] pb [12] = '{16'h0000, 16'hFFFF, 16'h1234, 16'h1235, 16'h7FFF, 16'h001F,
                                 16'h0F0F, 16'h5AA5, 16'h0000, 16'h0000, 16'h8000, 16'h0F01};

  initial begin
    a = '0; b = '0; part = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R1: idle operands, single lane, all six vectors checked together
    drive(16'h0000, 16'h0000, 3'b000, "R1");
    // R2: regular modes
    foreach (pa[i]) drive(pa[i], pb[i], 3'b000, "R2_16b");
    foreach (pa[i]) drive(pa[i], pb[i], 3'b010, "R2_8b");
    foreach (pa[i]) drive(pa[i], pb[i], 3'b111, "R2_4b");
    // R4: unsigned order inside a lane
    drive(16'h000F, 16'h0001, 3'b111, "R4");
    drive(16'h8000, 16'h0001, 3'b000, "R4");
    // R5: only one lane changes, others keep their flags
    drive(16'h1234, 16'h5234, 3'b111, "R5");
    drive(16'h1234, 16'h1230, 3'b111, "R5");
    drive(16'hFF00, 16'h0000, 3'b010, "R5");
    // R8: irregular splits
    for (int m = 1; m < 7; m++) begin
      if (m != 2) foreach (pa[i]) drive(pa[i], pb[i], m[PP-1:0], "R8");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule